// File: doc/BRIEF.md
# Timer with Input Capture

This block is a 16-bit up-counter with a capture register, two compare registers and interrupt logic, all reached over an 8-bit register bus. When the selected trigger shows a qualified edge, the counter value at that moment is copied into the capture register. The trigger is either a dedicated pin or an analog comparator output, chosen by a control bit. Each trigger input passes through a two-stage synchronizer before edge detection, and a parameter picks the active edge.

All four 16-bit registers (counter, capture, compare A, compare B) share one 8-bit high-byte staging register. Reading a low byte stores the matching high byte in the staging register. Writing a high byte only fills the staging register, and the next low-byte write commits all 16 bits at once. A mode bit turns the capture register into the counter's wrap limit.

Four interrupt sources (capture, compare A, compare B, overflow) each have a sticky flag and an enable bit. A request leaves the block only when the flag, its enable and the global interrupt enable input are all set.

Top module: `cap_timer_top`

## Requirements
- R1: After reset the counter, capture, both compare registers, control, enable and flag registers all read 0, and irq_o is 0.
- R2: With the pin source selected and the mode bit clear, a rising edge on cap_pin_i (default edge parameter) loads the capture register with the counter value. A falling edge does not load it.
- R3: Control bit 1 selects the trigger: 0 for cap_pin_i, 1 for cmp_out_i. Edges on the input that is not selected are ignored.
- R4: Reading a low byte returns that register's low byte and stores its high byte in the staging register. A read of any high-byte address returns the staging register.
- R5: Writing a high-byte address loads only the staging register and leaves the target unchanged. A low-byte write loads {staging, data} into the target in one cycle.
- R6: The staging register is shared by all four 16-bit registers. A high byte written at one register's address is committed by a low-byte write to another register.
- R7: While control bit 0 (run) is set, the counter increments once per clock. From 0xFFFF it wraps to 0 and sets the overflow flag (bit 2).
- R8: With control bit 2 (top mode) set, the counter wraps to 0 after the cycle in which it equals the capture register, and the overflow flag sets on that wrap. A capture event in this mode sets the capture flag but leaves the capture register unchanged.
- R9: While running, the counter equalling compare A sets flag bit 4, and equalling compare B sets flag bit 3.
- R10: The address map is: 0/1 counter low/high, 2/3 capture, 4/5 compare A, 6/7 compare B, 8 control, 9 enable, 10 flag. In both the enable and flag registers, bit 5 is capture, bit 4 compare A, bit 3 compare B and bit 2 overflow. All other bits read 0.
- R11: irq_o[3:0] maps to flag bits 5..2. Each bit is high exactly when its flag, its enable bit and gie_i are all 1.
- R12: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A set event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_en_i is high |
| cap_pin_i | input | 1 | Capture trigger pin |
| cmp_out_i | input | 1 | Analog comparator output, the alternative trigger |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 4 | Requests: [3] capture, [2] compare A, [1] compare B, [0] overflow |

## Verification
Two functions can land in the same cycle: a software write-1 clear of the capture flag and the capture event that sets it. The bench times a pin rise so that the synchronized edge appears in exactly the cycle the clear write is on the bus. It then reads the flag back, expecting 1. A clear issued with no event present is expected to leave the flag at 0. The compare sweeps and the staging-register sequences compute every expected value from the counter start value and the cycle count.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_L  = 4'd0,
    A_CNT_H  = 4'd1,
    A_CAP_L  = 4'd2,
    A_CAP_H  = 4'd3,
    A_CMPA_L = 4'd4,
    A_CMPA_H = 4'd5,
    A_CMPB_L = 4'd6,
    A_CMPB_H = 4'd7,
    A_CTRL   = 4'd8,
    A_IEN    = 4'd9,
    A_IFLG   = 4'd10
  } reg_addr_e;

  // interrupt field: contiguous bits, capture highest
  localparam int unsigned BIT_CAP  = 5;
  localparam int unsigned BIT_CMPA = 4;
  localparam int unsigned BIT_CMPB = 3;
  localparam int unsigned BIT_OVF  = 2;
  localparam int unsigned IRQ_N    = 4;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_SRC = 1;
  localparam int unsigned CTRL_TOP = 2;
  localparam int unsigned CTRL_W   = 3;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RISING      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic evt_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], sig_i};
      last_q <= sync_q[MSB];
    end
  end

  generate
    if (RISING) begin : g_rise
      assign evt_o = sync_q[MSB] & ~last_q;
    end else begin : g_fall
      assign evt_o = ~sync_q[MSB] & last_q;
    end
  endgenerate
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         top_mode_i,
  input  logic [W-1:0] top_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         match_a_o,
  output logic         match_b_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;
  logic         at_lim;
  logic         step;

  assign lim    = top_mode_i ? top_i : {W{1'b1}};
  assign at_lim = (cnt_q == lim);
  assign step   = run_i & ~load_i;

  assign wrap_o    = step & at_lim;
  assign match_a_o = step & (cnt_q == cmpa_i);
  assign match_b_o = step & (cnt_q == cmpb_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (run_i)   cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cap_irq_ctrl.sv
module cap_irq_ctrl #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         en_wr_i,
  input  logic         flag_wr_i,
  input  logic [N-1:0] wfield_i,
  input  logic         gie_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] flag_q;
  logic [N-1:0] clr;

  assign clr = flag_wr_i ? wfield_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wfield_i;
      flag_q <= (flag_q & ~clr) | set_i; // set wins
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_q & {N{gie_i}};
endmodule

// File: rtl/cap_timer_top.sv
module cap_timer_top
  import cap_timer_pkg::*;
#(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          CAPT_RISING = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     rdata_o,
  input  logic                 cap_pin_i,
  input  logic                 cmp_out_i,
  input  logic                 gie_i,
  output logic [IRQ_N-1:0]     irq_o
);
  localparam int unsigned CNT_W = 2 * BUS_W;

  logic [BUS_W-1:0]  temp_q;
  logic [CNT_W-1:0]  cap_q, cmpa_q, cmpb_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  wide_wval;
  logic              evt_pin, evt_cmp, cap_evt;
  logic              run, top_mode;
  logic              wrap, match_a, match_b;
  logic              wr_cnt_l, wr_cap_l, wr_cmpa_l, wr_cmpb_l, wr_hi;
  logic              wr_ctrl, wr_ien, wr_iflg;
  logic              rd_lo;
  logic [BUS_W-1:0]  rd_hi_src;
  logic [IRQ_N-1:0]  irq_set, irq_en, irq_flag;

  assign run      = ctrl_q[CTRL_RUN];
  assign top_mode = ctrl_q[CTRL_TOP];

  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES), .RISING(CAPT_RISING)) u_edge_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cap_pin_i), .evt_o(evt_pin)
  );
  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES), .RISING(CAPT_RISING)) u_edge_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cmp_out_i), .evt_o(evt_cmp)
  );
  assign cap_evt = ctrl_q[CTRL_SRC] ? evt_cmp : evt_pin;

  // bus decode
  assign wide_wval = {temp_q, wdata_i};
  assign wr_cnt_l  = wr_en_i && (addr_i == A_CNT_L);
  assign wr_cap_l  = wr_en_i && (addr_i == A_CAP_L);
  assign wr_cmpa_l = wr_en_i && (addr_i == A_CMPA_L);
  assign wr_cmpb_l = wr_en_i && (addr_i == A_CMPB_L);
  assign wr_hi     = wr_en_i && (addr_i < A_CTRL) && addr_i[0];
  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_ien    = wr_en_i && (addr_i == A_IEN);
  assign wr_iflg   = wr_en_i && (addr_i == A_IFLG);
  assign rd_lo     = rd_en_i && !wr_en_i && (addr_i < A_CTRL) && !addr_i[0];

  always_comb begin
    unique case (addr_i)
      A_CNT_L:  rd_hi_src = cnt[CNT_W-1:BUS_W];
      A_CAP_L:  rd_hi_src = cap_q[CNT_W-1:BUS_W];
      A_CMPA_L: rd_hi_src = cmpa_q[CNT_W-1:BUS_W];
      default:  rd_hi_src = cmpb_q[CNT_W-1:BUS_W];
    endcase
  end

  cap_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(run), .top_mode_i(top_mode), .top_i(cap_q),
    .load_i(wr_cnt_l), .load_val_i(wide_wval),
    .cmpa_i(cmpa_q), .cmpb_i(cmpb_q),
    .cnt_o(cnt), .wrap_o(wrap), .match_a_o(match_a), .match_b_o(match_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      cap_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_hi)      temp_q <= wdata_i;
      else if (rd_lo) temp_q <= rd_hi_src;

      // capture has priority over a bus write
      if (cap_evt && !top_mode) cap_q <= cnt;
      else if (wr_cap_l)        cap_q <= wide_wval;

      if (wr_cmpa_l) cmpa_q <= wide_wval;
      if (wr_cmpb_l) cmpb_q <= wide_wval;
      if (wr_ctrl)   ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  assign irq_set = {cap_evt, match_a, match_b, wrap};

  cap_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(irq_set), .en_wr_i(wr_ien), .flag_wr_i(wr_iflg),
    .wfield_i(wdata_i[BIT_OVF +: IRQ_N]), .gie_i(gie_i),
    .en_o(irq_en), .flag_o(irq_flag), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_CNT_L:  rdata_o = cnt[BUS_W-1:0];
        A_CAP_L:  rdata_o = cap_q[BUS_W-1:0];
        A_CMPA_L: rdata_o = cmpa_q[BUS_W-1:0];
        A_CMPB_L: rdata_o = cmpb_q[BUS_W-1:0];
        A_CNT_H, A_CAP_H, A_CMPA_H, A_CMPB_H: rdata_o = temp_q;
        A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
        A_IEN:    rdata_o[BIT_OVF +: IRQ_N] = irq_en;
        A_IFLG:   rdata_o[BIT_OVF +: IRQ_N] = irq_flag;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [BUS_W-1:0]    rdata_o,
  input logic                gie_i,
  input logic [IRQ_N-1:0]    irq_o,
  input logic                cap_evt,
  input logic                top_mode,
  input logic                run,
  input logic [CNT_W-1:0]    cnt,
  input logic [CNT_W-1:0]    cap_q,
  input logic [BUS_W-1:0]    temp_q,
  input logic [IRQ_N-1:0]    irq_flag
);
  // R2
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && !top_mode) |=> (cap_q == $past(cnt)));

  // R8
  top_cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && top_mode && !(wr_en_i && addr_i == A_CAP_L)) |=> $stable(cap_q));

  // R12
  cap_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> irq_flag[IRQ_N-1]);

  // R7
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !top_mode && !(wr_en_i && addr_i == A_CNT_L) && cnt == {CNT_W{1'b1}})
    |=> (cnt == '0 && irq_flag[0]));

  // R4
  temp_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == A_CNT_L) |=> (temp_q == $past(cnt[CNT_W-1:BUS_W])));

  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> (gie_i && ((irq_o & ~irq_flag) == '0)));

  // R10
  flag_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_IFLG) |-> ((rdata_o & 8'hC3) == '0));
endmodule

bind cap_timer_top cap_timer_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .rdata_o(rdata_o), .gie_i(gie_i), .irq_o(irq_o),
  .cap_evt(cap_evt), .top_mode(top_mode), .run(run), .cnt(cnt),
  .cap_q(cap_q), .temp_q(temp_q), .irq_flag(irq_flag)
);

// File: tb/tb_cap_timer_top.sv
module tb_cap_timer_top;
  import cap_timer_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        cap_pin_i = 1'b0, cmp_out_i = 1'b0, gie_i = 1'b0;
  logic [3:0]  irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  rb;
  logic [15:0] rw;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cap_timer_top dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a_lo, input logic [15:0] v);
    wr(a_lo + 4'd1, v[15:8]);
    wr(a_lo, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] a_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse(input bit use_cmp);
    @(negedge clk_i);
    if (use_cmp) cmp_out_i = 1'b1; else cap_pin_i = 1'b1;
    repeat (4) @(negedge clk_i);
    cmp_out_i = 1'b0; cap_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic run_for(input int n);
    logic [7:0] c;
    rd(A_CTRL, c);
    wr(A_CTRL, c | 8'h01);
    repeat (n) @(negedge clk_i);
    wr(A_CTRL, c & 8'hFE);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h1234, 16'hABCD, 16'hFFFF, 16'h00FF, 16'h8001};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 10; a++) begin
      rd(a[3:0], rb);
      chk("R1 reset reg", {8'h0, rb}, 16'h0);
    end
    chk("R1 irq reset", {12'h0, irq_o}, 16'h0);

    // R10 enable register field
    wr(A_IEN, 8'hFF);
    rd(A_IEN, rb);
    chk("R10 enable bits", {8'h0, rb}, 16'h003C);
    wr(A_IEN, 8'h00);

    // R2 capture sweep on rising pin edge
    foreach (vals[i]) begin
      wr16(A_CNT_L, vals[i]);
      pulse(1'b0);
      rd16(A_CAP_L, rw);
      chk("R2 capture value", rw, vals[i]);
    end
    rd(A_IFLG, rb);
    chk("R10 capture flag bit5", {8'h0, rb}, 16'h0020);
    wr(A_IFLG, 8'h20);

    // R2 falling edge ignored
    wr16(A_CNT_L, 16'h5A5A);
    @(negedge clk_i); cap_pin_i = 1'b1;
    repeat (5) @(negedge clk_i);
    wr16(A_CNT_L, 16'h4444);
    cap_pin_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rd16(A_CAP_L, rw);
    chk("R2 falling edge no capture", rw, 16'h5A5A);

    // R3 source select
    wr(A_CTRL, 8'h02);
    wr16(A_CNT_L, 16'h0BAD);
    pulse(1'b0);
    rd16(A_CAP_L, rw);
    chk("R3 pin ignored when comparator selected", rw, 16'h5A5A);
    pulse(1'b1);
    rd16(A_CAP_L, rw);
    chk("R3 comparator capture", rw, 16'h0BAD);
    wr(A_CTRL, 8'h00);
    wr16(A_CNT_L, 16'h0C0C);
    pulse(1'b1);
    rd16(A_CAP_L, rw);
    chk("R3 comparator ignored when pin selected", rw, 16'h0BAD);

    // R4 staging latch on low read
    wr16(A_CNT_L, 16'hABCD);
    pulse(1'b0);
    wr16(A_CNT_L, 16'h5600);
    rd(A_CAP_L, rb);
    chk("R4 low byte", {8'h0, rb}, 16'h00CD);
    pulse(1'b0);
    rd(A_CAP_H, rb);
    chk("R4 high from staging", {8'h0, rb}, 16'h00AB);
    rd16(A_CAP_L, rw);
    chk("R4 fresh pair", rw, 16'h5600);

    // R5 / R6 staged writes
    wr16(A_CMPA_L, 16'h1111);
    wr(A_CMPA_H, 8'h22);
    wr(A_CMPB_L, 8'h44);
    rd16(A_CMPB_L, rw);
    chk("R6 shared staging commit", rw, 16'h2244);
    rd16(A_CMPA_L, rw);
    chk("R5 high write alone no effect", rw, 16'h1111);

    // R12 write-1-clear, write-0 no effect, set wins
    wr(A_IFLG, 8'hFF);
    pulse(1'b0);
    wr(A_IFLG, 8'h00);
    rd(A_IFLG, rb);
    chk("R12 write 0 keeps flag", {8'h0, rb}, 16'h0020);
    wr(A_IFLG, 8'h20);
    rd(A_IFLG, rb);
    chk("R12 write 1 clears", {8'h0, rb}, 16'h0000);
    @(negedge clk_i); cap_pin_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); addr_i = A_IFLG; wdata_i = 8'h20; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
    rd(A_IFLG, rb);
    chk("R12 set wins over clear", {8'h0, rb}, 16'h0020);

    // R11 gating
    wr(A_IEN, 8'h20);
    gie_i = 1'b0; #1;
    chk("R11 gie low", {12'h0, irq_o}, 16'h0);
    @(negedge clk_i); gie_i = 1'b1; #1;
    chk("R11 request", {12'h0, irq_o}, 16'h0008);
    wr(A_IEN, 8'h00); #1;
    chk("R11 enable low", {12'h0, irq_o}, 16'h0);
    @(negedge clk_i); cap_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
    wr(A_IFLG, 8'hFF);

    // R7 overflow wrap: n=30 -> 32 increments
    wr16(A_CNT_L, 16'hFFF0);
    run_for(30);
    rd16(A_CNT_L, rw);
    chk("R7 counter after wrap", rw, 16'h0010);
    rd(A_IFLG, rb);
    chk("R7 overflow flag", {8'h0, rb}, 16'h0004);

    // R9 compare sweep: start 0, n=10 -> values 0..11 evaluated
    for (int c = 0; c < 16; c++) begin
      wr(A_IFLG, 8'hFF);
      wr16(A_CMPA_L, 16'(c));
      wr16(A_CMPB_L, 16'(15 - c));
      wr16(A_CNT_L, 16'h0000);
      run_for(10);
      rd(A_IFLG, rb);
      chk("R9 compare flags", {8'h0, rb & 8'h18},
          {8'h0, 3'b000, (c <= 11), (15 - c <= 11), 3'b000});
    end
    rd16(A_CNT_L, rw);
    chk("R9 counter end", rw, 16'd12);

    // R8 top mode: TOP=9, 32 increments -> 2
    wr(A_IFLG, 8'hFF);
    wr16(A_CAP_L, 16'd9);
    wr16(A_CNT_L, 16'd0);
    wr(A_CTRL, 8'h04);
    run_for(30);
    rd16(A_CNT_L, rw);
    chk("R8 counter wraps at top", rw, 16'd2);
    rd(A_IFLG, rb);
    chk("R8 overflow at top", {8'h0, rb & 8'h04}, 16'h0004);
    wr(A_IFLG, 8'hFF);
    wr16(A_CNT_L, 16'h0777);
    pulse(1'b0);
    rd(A_IFLG, rb);
    chk("R8 capture flag in top mode", {8'h0, rb & 8'h20}, 16'h0020);
    rd16(A_CAP_L, rw);
    chk("R8 capture reg held", rw, 16'd9);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule